// File: doc/BRIEF.md
# Programmable CRC-32 Register Unit

This block computes a 32-bit cyclic redundancy check over data that software pushes through a small register bus. A running remainder is advanced once for every accepted write to the data register. The number of bits folded in is set by the size of that write: a single byte lane, an aligned half-word, or the full word. The generator polynomial and the starting value are both held in registers, so one instance serves CRC-32, CRC-32C or any other 32-bit polynomial.

The remainder is computed MSB-first. Before each fold, the incoming item can have its bit order mirrored at byte, half-word or word granularity. The value read back can also be returned bit-mirrored. Together these let software run reflected algorithms on the non-reflected engine. Software applies any final inversion itself.

The bus never applies back-pressure. Every access completes in the cycle it is presented, and read data is combinational from the current state. A suspended computation is continued by loading the remainder it read back into the start-value register and issuing a reload.

Top module: `crc_mmio_unit`

## Requirements
- R1: After reset, the start-value register reads 0xFFFFFFFF, the polynomial register reads 0x04C11DB7, the control register reads 0, and the remainder equals 0xFFFFFFFF.
- R2: The data register sits at offset 0x00, control at 0x08, start value at 0x10 and polynomial at 0x14. Reads of any other offset return 0, and writes to any other offset change nothing.
- R3: Writing control with bit 0 set loads the remainder from the start-value register on that clock edge. Control bit 0 always reads back as 0.
- R4: A data write with byte enables 4'b1111 XORs the item into the remainder and advances the remainder by 32 MSB-first polynomial steps in a single clock.
- R5: A data write with byte enables 4'b0011 (item from bits [15:0]) or 4'b1100 (item from bits [31:16]) XORs the 16-bit item into remainder bits [31:16] and advances 16 steps.
- R6: A data write with exactly one byte enable set takes the 8-bit item from that lane, XORs it into remainder bits [31:24] and advances 8 steps.
- R7: Control bits [6:5] mirror the item before the fold. 2'b00 leaves it unchanged. 2'b01 mirrors each byte. 2'b10 mirrors each 16-bit half. 2'b11 mirrors the whole item. A unit wider than the item shrinks to the item's size.
- R8: With control bit 7 set, reading the data register returns the remainder with all 32 bits in reverse order. With bit 7 clear, the read returns the remainder as it is.
- R9: Data writes with any byte-enable pattern other than those in R4 to R6 leave the remainder unchanged, and no bus read changes it.
- R10: The polynomial register is fully writable. With reflected settings (byte mirroring, output mirroring, start value 0xFFFFFFFF, final inversion in software), the ASCII string "123456789" yields 0xCBF43926 with polynomial 0x04C11DB7 and 0xE3069283 with polynomial 0x1EDC6F41.
- R11: A computation split at any write boundary gives the same remainder when it is resumed. To resume, write the remainder read back (with bit 7 clear) to the start-value register, then issue a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_be | input | 4 | Byte enables of a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |

## Verification
On every cycle, the assertions check that a reload copies the start value into the remainder, and that ignored data writes, reads and unmapped writes leave the remainder untouched. They also check that control bit 0 and unmapped offsets always read as zero. The arithmetic of the folds, the mirroring modes, output mirroring, the known CRC-32 and CRC-32C check values and resumption are shown only by the bench's sweeps against its own model.

// File: rtl/crc_mmio_pkg.sv
package crc_mmio_pkg;
  localparam int DW = 32;
  localparam int BE_W = DW / 8;

  localparam logic [7:0] OFS_DATA = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_INIT = 8'h10;
  localparam logic [7:0] OFS_POLY = 8'h14;

  typedef enum logic [1:0] {REV_NONE, REV_BYTE, REV_HALF, REV_WORD} rev_mode_e;
  typedef enum logic [1:0] {SZ_NONE, SZ_BYTE, SZ_HALF, SZ_WORD} step_size_e;

  function automatic logic [DW-1:0] mirror_word(input logic [DW-1:0] x);
    logic [DW-1:0] y;
    for (int i = 0; i < DW; i++) y[i] = x[DW-1-i];
    return y;
  endfunction

  function automatic logic [DW-1:0] merge_be(input logic [DW-1:0] old,
                                             input logic [DW-1:0] nw,
                                             input logic [BE_W-1:0] be);
    logic [DW-1:0] r;
    r = old;
    for (int b = 0; b < BE_W; b++)
      if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/crc_lane_pick.sv
module crc_lane_pick
  import crc_mmio_pkg::*;
(
  input  logic [BE_W-1:0] be,
  input  logic [DW-1:0]   wdata,
  input  rev_mode_e       mode,
  output step_size_e      size,
  output logic [DW-1:0]   item
);
  logic [DW-1:0] raw;
  int nbits;
  int unit;

  always_comb begin
    raw  = '0;
    size = SZ_NONE;
    case (be)
      4'b0001: begin size = SZ_BYTE; raw[7:0] = wdata[7:0];   end
      4'b0010: begin size = SZ_BYTE; raw[7:0] = wdata[15:8];  end
      4'b0100: begin size = SZ_BYTE; raw[7:0] = wdata[23:16]; end
      4'b1000: begin size = SZ_BYTE; raw[7:0] = wdata[31:24]; end
      4'b0011: begin size = SZ_HALF; raw[15:0] = wdata[15:0];  end
      4'b1100: begin size = SZ_HALF; raw[15:0] = wdata[31:16]; end
      4'b1111: begin size = SZ_WORD; raw = wdata; end
      default: ;
    endcase
    case (size)
      SZ_BYTE: nbits = 8;
      SZ_HALF: nbits = 16;
      SZ_WORD: nbits = 32;
      default: nbits = 0;
    endcase
    case (mode)
      REV_BYTE: unit = 8;
      REV_HALF: unit = 16;
      REV_WORD: unit = 32;
      default:  unit = 1;
    endcase
    if (unit > nbits) unit = nbits;
    if (unit < 1) unit = 1;
    item = '0;
    for (int i = 0; i < DW; i++)
      if (i < nbits) item[(i / unit) * unit + (unit - 1 - (i % unit))] = raw[i];
  end
endmodule

// File: rtl/crc_fold.sv
module crc_fold
  import crc_mmio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [DW-1:0] rem,
  input  logic [W-1:0]  chunk,
  input  logic [DW-1:0] poly,
  output logic [DW-1:0] next
);
  always_comb begin
    next = rem ^ (DW'(chunk) << (DW - W));
    for (int k = 0; k < W; k++)
      next = next[DW-1] ? ((next << 1) ^ poly) : (next << 1);
  end
endmodule

// File: rtl/crc_mmio_unit.sv
module crc_mmio_unit
  import crc_mmio_pkg::*;
#(
  parameter int          ADDR_W   = 5,
  parameter logic [31:0] INIT_RST = 32'hFFFF_FFFF,
  parameter logic [31:0] POLY_RST = 32'h04C1_1DB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int NSIZES = 3;

  logic [DW-1:0] rem_q, init_q, poly_q;
  rev_mode_e     rev_in_q;
  logic          rev_out_q;

  logic [7:0] ofs;
  logic hit_data, hit_ctrl, hit_init, hit_poly, wr;

  always_comb begin
    ofs      = 8'(bus_addr);
    hit_data = (ofs == OFS_DATA);
    hit_ctrl = (ofs == OFS_CTRL);
    hit_init = (ofs == OFS_INIT);
    hit_poly = (ofs == OFS_POLY);
    wr       = bus_sel && bus_we;
  end

  step_size_e    size;
  logic [DW-1:0] item;
  logic [DW-1:0] nxt [NSIZES];

  crc_lane_pick u_pick (
    .be(bus_be), .wdata(bus_wdata), .mode(rev_in_q), .size(size), .item(item)
  );

  for (genvar g = 0; g < NSIZES; g++) begin : g_fold
    localparam int GW = 8 << g;
    crc_fold #(.W(GW)) u_fold (
      .rem(rem_q), .chunk(item[GW-1:0]), .poly(poly_q), .next(nxt[g])
    );
  end

  logic [DW-1:0] rem_step;
  always_comb begin
    case (size)
      SZ_BYTE: rem_step = nxt[0];
      SZ_HALF: rem_step = nxt[1];
      SZ_WORD: rem_step = nxt[2];
      default: rem_step = rem_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q     <= INIT_RST;
      init_q    <= INIT_RST;
      poly_q    <= POLY_RST;
      rev_in_q  <= REV_NONE;
      rev_out_q <= 1'b0;
    end else if (wr) begin
      if (hit_data) rem_q <= rem_step;
      if (hit_init) init_q <= merge_be(init_q, bus_wdata, bus_be);
      if (hit_poly) poly_q <= merge_be(poly_q, bus_wdata, bus_be);
      if (hit_ctrl && bus_be[0]) begin
        rev_in_q  <= rev_mode_e'(bus_wdata[6:5]);
        rev_out_q <= bus_wdata[7];
        if (bus_wdata[0]) rem_q <= init_q;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_data)      bus_rdata = rev_out_q ? mirror_word(rem_q) : rem_q;
    else if (hit_ctrl) bus_rdata = {24'h0, rev_out_q, rev_in_q, 5'b0};
    else if (hit_init) bus_rdata = init_q;
    else if (hit_poly) bus_rdata = poly_q;
  end
endmodule

// File: rtl/crc_mmio_checker.sv
module crc_mmio_checker #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       rem_q,
  input logic [31:0]       init_q
);
  logic [7:0] a;
  logic mapped, be_ok;
  assign a = 8'(bus_addr);
  assign mapped = (a == 8'h00) || (a == 8'h08) || (a == 8'h10) || (a == 8'h14);
  assign be_ok = (bus_be == 4'b1111) || (bus_be == 4'b0011) || (bus_be == 4'b1100)
              || ($countones(bus_be) == 1);

  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && a == 8'h08 && bus_be[0] && bus_wdata[0])
      |=> (rem_q == $past(init_q)));

  a_r3_bit0_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && a == 8'h08) |-> (bus_rdata[0] == 1'b0));

  a_r9_bad_be_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && a == 8'h00 && !be_ok) |=> $stable(rem_q));

  a_r9_read_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we) |=> $stable(rem_q));

  a_r2_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && !mapped) |-> (bus_rdata == 32'h0));

  a_r2_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && !mapped) |=> ($stable(rem_q) && $stable(init_q)));
endmodule

bind crc_mmio_unit crc_mmio_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .rem_q(rem_q), .init_q(init_q)
);

// File: tb/sim_crc_mmio_unit.sv
module sim_crc_mmio_unit;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  crc_mmio_unit u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ad, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = ad[4:0]; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_be = '0;
  endtask

  task automatic rd(input logic [7:0] ad, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = ad[4:0];
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  function automatic logic [31:0] m_fold(input logic [31:0] r, input logic [31:0] d,
                                         input int n, input logic [31:0] p);
    r = r ^ (d << (32 - n));
    for (int k = 0; k < n; k++) r = r[31] ? ((r << 1) ^ p) : (r << 1);
    return r;
  endfunction

  function automatic logic [31:0] m_rev(input logic [31:0] x, input int n);
    logic [31:0] y = '0;
    for (int i = 0; i < n; i++) y[n-1-i] = x[i];
    return y;
  endfunction

  // Expected item and size from the byte-enable rules of R4..R7.
  function automatic int m_pick(input logic [3:0] be, input logic [31:0] d,
                                input int mode, output logic [31:0] it);
    int n; int u; logic [31:0] raw;
    n = 0; raw = '0;
    case (be)
      4'b0001: begin n = 8;  raw = d & 32'hFF; end
      4'b0010: begin n = 8;  raw = (d >> 8) & 32'hFF; end
      4'b0100: begin n = 8;  raw = (d >> 16) & 32'hFF; end
      4'b1000: begin n = 8;  raw = d >> 24; end
      4'b0011: begin n = 16; raw = d & 32'hFFFF; end
      4'b1100: begin n = 16; raw = d >> 16; end
      4'b1111: begin n = 32; raw = d; end
      default: n = 0;
    endcase
    u = (mode == 0) ? 1 : (mode == 1) ? 8 : (mode == 2) ? 16 : 32;
    if (u > n) u = n;
    it = '0;
    for (int c = 0; c < 32; c += 8)
      if (u > 1 && c < n && (c % u) == 0) it |= m_rev((raw >> c), u) << c;
    if (u <= 1) it = raw;
    return n;
  endfunction

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got %08h expected %08h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, exp_rem, it, r_full, r_part;
    string s1;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(8'h10, v); check("R1 init", v, 32'hFFFF_FFFF);
    rd(8'h14, v); check("R1 poly", v, 32'h04C1_1DB7);
    rd(8'h08, v); check("R1 ctrl", v, 32'h0);
    rd(8'h00, v); check("R1 remainder", v, 32'hFFFF_FFFF);

    // R2 unmapped offsets
    rd(8'h04, v); check("R2 unmapped read", v, 32'h0);
    wr(8'h0C, 4'b1111, 32'h1234_5678);
    rd(8'h00, v); check("R2 unmapped write", v, 32'hFFFF_FFFF);

    // R4..R7, R9 sweep: every mode, every byte-enable pattern
    exp_rem = 32'hFFFF_FFFF;
    for (int mode = 0; mode < 4; mode++) begin
      wr(8'h08, 4'b0001, 32'(mode << 5));
      rd(8'h08, v); check("R3 ctrl readback bit0 zero", v, 32'(mode << 5));
      for (int be = 0; be < 16; be++) begin
        for (int t = 0; t < 2; t++) begin
          logic [31:0] d;
          int n;
          d = 32'h9E37_79B9 * (be * 7 + t * 3 + mode + 1);
          wr(8'h00, 4'(be), d);
          n = m_pick(4'(be), d, mode, it);
          if (n > 0) exp_rem = m_fold(exp_rem, it, n, 32'h04C1_1DB7);
          rd(8'h00, v);
          s1 = (n == 32) ? "R4 word" : (n == 16) ? "R5 half" :
               (n == 8) ? "R6 byte" : "R9 ignored be";
          check(mode == 0 ? s1 : {"R7 mirror ", s1}, v, exp_rem);
        end
      end
    end

    // R8 output mirroring
    wr(8'h08, 4'b0001, 32'h80);
    rd(8'h00, v); check("R8 mirrored read", v, m_rev(exp_rem, 32));
    wr(8'h08, 4'b0001, 32'h00);
    rd(8'h00, v); check("R8 plain read", v, exp_rem);

    // R3 reload
    wr(8'h10, 4'b1111, 32'hA5A5_0F0F);
    wr(8'h08, 4'b0001, 32'h01);
    rd(8'h00, v); check("R3 reload", v, 32'hA5A5_0F0F);

    // R10 check values, byte path and word path
    for (int alg = 0; alg < 2; alg++) begin
      logic [31:0] p;
      p = alg ? 32'h1EDC_6F41 : 32'h04C1_1DB7;
      wr(8'h14, 4'b1111, p);
      wr(8'h10, 4'b1111, 32'hFFFF_FFFF);
      wr(8'h08, 4'b0001, 32'hA1);
      for (int i = 0; i < 9; i++) wr(8'h00, 4'b0001, 32'(8'h31 + i));
      rd(8'h00, v);
      check(alg ? "R10 crc32c bytes" : "R10 crc32 bytes", ~v, alg ? 32'hE306_9283 : 32'hCBF4_3926);
      wr(8'h08, 4'b0001, 32'hE1);
      wr(8'h00, 4'b1111, 32'h3433_3231);
      wr(8'h00, 4'b1111, 32'h3837_3635);
      wr(8'h08, 4'b0001, 32'hA0);
      wr(8'h00, 4'b0001, 32'h39);
      rd(8'h00, v);
      check(alg ? "R10 crc32c words" : "R10 crc32 words", ~v, alg ? 32'hE306_9283 : 32'hCBF4_3926);
    end

    // R11 resume after split
    wr(8'h14, 4'b1111, 32'h04C1_1DB7);
    wr(8'h10, 4'b1111, 32'h1357_9BDF);
    wr(8'h08, 4'b0001, 32'h01);
    wr(8'h00, 4'b1111, 32'hDEAD_BEEF);
    wr(8'h00, 4'b1100, 32'hC0DE_0000);
    wr(8'h00, 4'b0010, 32'h0000_7700);
    rd(8'h00, r_full);
    wr(8'h10, 4'b1111, 32'h1357_9BDF);
    wr(8'h08, 4'b0001, 32'h01);
    wr(8'h00, 4'b1111, 32'hDEAD_BEEF);
    rd(8'h00, r_part);
    wr(8'h10, 4'b1111, r_part);
    wr(8'h14, 4'b1111, 32'h04C1_1DB7);
    wr(8'h08, 4'b0001, 32'h01);
    wr(8'h00, 4'b1100, 32'hC0DE_0000);
    wr(8'h00, 4'b0010, 32'h0000_7700);
    rd(8'h00, v); check("R11 resume", v, r_full);
    exp_rem = m_fold(m_fold(m_fold(32'h1357_9BDF, 32'hDEAD_BEEF, 32, 32'h04C1_1DB7),
                     32'hC0DE, 16, 32'h04C1_1DB7), 32'h77, 8, 32'h04C1_1DB7);
    check("R11 model", r_full, exp_rem);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule